// File: doc/BRIEF.md
# State-Driven Processor Clock Source Selector

This block picks the clock that drives a processor core from up to sixteen candidate sources. The choice depends on a 4-bit power/interrupt state. A control word holds that state next to four 4-bit source codes, one for each of the idle, run, IRQ and FIQ states. The block decodes the state, takes the matching source code and steers a glitch-free clock multiplexer to that input. A change of the state field alone is therefore enough to move the core onto a different clock.

Software updates the control word through a small write port. A write either replaces the whole word or changes a single field and leaves every other field as it was. Each clock input has its own gating cell. Before a new source is enabled, the outgoing source is stopped on one of its own falling edges. The incoming source is then synchronised over two of its rising edges and opened on its next falling edge. The output never shows a pulse narrower than a half-period of the sources involved. In the standby state, in an unused state code, or when a source code is not implemented, the output is held low.

Top module: `cpu_clk_state_mux`

## Requirements
- R1: When synchronous reset is released, the control word reads 0x2000_0000 (run state, every source code 0), and once the switch settles the output follows input 0.
- R2: A write with wr_field = 0 loads bits 31:28 (state) and bits 15:0 (source codes) from wr_data. Bits 27:16 of the control word always read zero.
- R3: A write with wr_field = 1 (state), 2 (idle, bits 3:0), 3 (run, bits 7:4), 4 (IRQ, bits 11:8) or 5 (FIQ, bits 15:12) copies wr_data[3:0] into that field only. wr_field = 6 or 7, or wr_en low, leaves the word unchanged.
- R4: State codes 1, 2, 3 and 4 select the idle, run, IRQ and FIQ source codes respectively. active_src and src_valid are registered and change one clock after the control word.
- R5: State code 0 (standby) and the unused codes 5 to 15 give src_valid = 0 and active_src = 0, and hold clk_out low.
- R6: A selected source code at or above N_SRC gives src_valid = 0, reports the code on active_src, and holds clk_out low.
- R7: Changing only the state field moves the output to the source code stored for the new state.
- R8: Once a switch has settled, clk_out shows the same rising edges as the selected input.
- R9: clk_out never shows a high or low pulse shorter than the shortest source half-period, including across switches at arbitrary phase.
- R10: At most one input gate is open at any time, so the settled output carries the edges of exactly one source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock for the register and the decode |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of every source |
| wr_en | input | 1 | Write strobe for the control word |
| wr_field | input | 3 | Write target: 0 whole word, 1 state, 2 idle, 3 run, 4 IRQ, 5 FIQ |
| wr_data | input | 32 | Write data; single-field writes use bits 3:0 |
| src_clk | input | N_SRC | Candidate clock inputs, index equals source code |
| ctrl_word | output | 32 | Current control word |
| active_src | output | 4 | Source code picked by the current state |
| src_valid | output | 1 | The state and the picked code name an implemented input |
| clk_out | output | 1 | Selected, glitch-free output clock |

## Verification
The hardest situation to reach from the ports is a switch whose handover lands at an awkward phase. The outgoing clock may be partway through a high phase while the incoming clock's edges sit close to it. The bench runs every source at a different, mutually incommensurate period with its own start offset, and randomly timed writes then land the handover at many different relative phases. Throughout the run it measures the interval between every pair of output edges, and it also compares the output's edge count with the selected source over a settled window. State-only writes, out-of-range codes and the standby state are driven directly, so that the high-code boundary and the hold-low paths are covered.

// File: rtl/cksel_pkg.sv
`timescale 1ns/1ps
package cksel_pkg;

  localparam int FIELD_W = 4;
  localparam int WORD_W  = 32;
  localparam int MAX_SRC = 1 << FIELD_W;

  typedef enum logic [3:0] {
    ST_STANDBY = 4'd0,
    ST_IDLE    = 4'd1,
    ST_RUN     = 4'd2,
    ST_IRQ     = 4'd3,
    ST_FIQ     = 4'd4
  } cpu_state_e;

  typedef enum logic [2:0] {
    FLD_WORD  = 3'd0,
    FLD_STATE = 3'd1,
    FLD_IDLE  = 3'd2,
    FLD_RUN   = 3'd3,
    FLD_IRQ   = 3'd4,
    FLD_FIQ   = 3'd5
  } wr_target_e;

  // Packed order puts the source codes in the low 16 bits of the word.
  typedef struct packed {
    logic [FIELD_W-1:0] state;
    logic [FIELD_W-1:0] fiq;
    logic [FIELD_W-1:0] irq;
    logic [FIELD_W-1:0] run;
    logic [FIELD_W-1:0] idle;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
    return {c.state, 12'h000, c.fiq, c.irq, c.run, c.idle};
  endfunction

endpackage

// File: rtl/cksel_ctrl_reg.sv
`timescale 1ns/1ps
module cksel_ctrl_reg
  import cksel_pkg::*;
#(
  parameter logic [FIELD_W-1:0] RST_STATE = 4'd2,
  parameter logic [FIELD_W-1:0] RST_SRC   = 4'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_field,
  input  logic [WORD_W-1:0] wr_data,
  output ctrl_t             ctrl_q
);

  logic [FIELD_W-1:0] nib;
  assign nib = wr_data[FIELD_W-1:0];

  // Bits 27:16 have no storage behind them.
  logic unused_hi;
  assign unused_hi = ^wr_data[27:16];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q.state <= RST_STATE;
      ctrl_q.fiq   <= RST_SRC;
      ctrl_q.irq   <= RST_SRC;
      ctrl_q.run   <= RST_SRC;
      ctrl_q.idle  <= RST_SRC;
    end else if (wr_en) begin
      case (wr_target_e'(wr_field))
        FLD_WORD: begin
          ctrl_q.state <= wr_data[31:28];
          ctrl_q.fiq   <= wr_data[15:12];
          ctrl_q.irq   <= wr_data[11:8];
          ctrl_q.run   <= wr_data[7:4];
          ctrl_q.idle  <= wr_data[3:0];
        end
        FLD_STATE: ctrl_q.state <= nib;
        FLD_IDLE:  ctrl_q.idle  <= nib;
        FLD_RUN:   ctrl_q.run   <= nib;
        FLD_IRQ:   ctrl_q.irq   <= nib;
        FLD_FIQ:   ctrl_q.fiq   <= nib;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cksel_decode.sv
`timescale 1ns/1ps
module cksel_decode
  import cksel_pkg::*;
#(
  parameter int N_SRC = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctrl,
  output logic [FIELD_W-1:0] active_src,
  output logic               src_valid,
  output logic [N_SRC-1:0]   sel_hot
);

  localparam logic [FIELD_W:0] N_LIM = (FIELD_W+1)'(N_SRC);

  logic [FIELD_W-1:0] pick;
  logic               state_ok;
  logic               in_range;
  logic [N_SRC-1:0]   hot_d;

  always_comb begin
    pick     = '0;
    state_ok = 1'b0;
    case (ctrl.state)
      ST_IDLE: begin pick = ctrl.idle; state_ok = 1'b1; end
      ST_RUN:  begin pick = ctrl.run;  state_ok = 1'b1; end
      ST_IRQ:  begin pick = ctrl.irq;  state_ok = 1'b1; end
      ST_FIQ:  begin pick = ctrl.fiq;  state_ok = 1'b1; end
      default: begin pick = '0;        state_ok = 1'b0; end
    endcase
  end

  assign in_range = ({1'b0, pick} < N_LIM);

  for (genvar i = 0; i < N_SRC; i++) begin : g_hot
    assign hot_d[i] = state_ok && in_range && (pick == FIELD_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_src <= '0;
      src_valid  <= 1'b0;
      sel_hot    <= '0;
    end else begin
      active_src <= pick;
      src_valid  <= state_ok && in_range;
      sel_hot    <= hot_d;
    end
  end

endmodule

// File: rtl/cksel_gate_cell.sv
`timescale 1ns/1ps
module cksel_gate_cell (
  input  logic src_clk,
  input  logic rst,
  input  logic req,
  input  logic others_busy,
  output logic en,
  output logic busy
);

  logic want;
  logic sync1;
  logic sync2;

  // A cell asks to open only while every other cell is fully closed.
  assign want = req & ~others_busy;

  always_ff @(posedge src_clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= want;
      sync2 <= sync1;
    end
  end

  // The gate moves only while this clock is low.
  always_ff @(negedge src_clk) begin
    if (rst) en <= 1'b0;
    else     en <= sync2;
  end

  assign busy = sync1 | sync2 | en;

endmodule

// File: rtl/cpu_clk_state_mux.sv
`timescale 1ns/1ps
module cpu_clk_state_mux
  import cksel_pkg::*;
#(
  parameter int N_SRC = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_field,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [N_SRC-1:0]   src_clk,
  output logic [WORD_W-1:0]  ctrl_word,
  output logic [FIELD_W-1:0] active_src,
  output logic               src_valid,
  output logic               clk_out
);

  ctrl_t            ctrl_q;
  logic [N_SRC-1:0] sel_hot;
  logic [N_SRC-1:0] gate_en;
  logic [N_SRC-1:0] busy;
  logic [N_SRC-1:0] others_busy;

  cksel_ctrl_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_field (wr_field),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q)
  );

  assign ctrl_word = ctrl_to_word(ctrl_q);

  cksel_decode #(.N_SRC(N_SRC)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl_q),
    .active_src (active_src),
    .src_valid  (src_valid),
    .sel_hot    (sel_hot)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_cell
    assign others_busy[i] = |(busy & ~(N_SRC'(1) << i));

    cksel_gate_cell u_cell (
      .src_clk     (src_clk[i]),
      .rst         (rst),
      .req         (sel_hot[i]),
      .others_busy (others_busy[i]),
      .en          (gate_en[i]),
      .busy        (busy[i])
    );
  end

  assign clk_out = |(src_clk & gate_en);

endmodule

// File: rtl/cksel_chk.sv
`timescale 1ns/1ps
module cksel_chk #(
  parameter int N_SRC = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_field,
  input logic [31:0]      wr_data,
  input logic [31:0]      ctrl_word,
  input logic [3:0]       active_src,
  input logic             src_valid,
  input logic [N_SRC-1:0] gate_en
);

  localparam logic [4:0] N_LIM = 5'(N_SRC);

  assert_reset_word_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ctrl_word == 32'h2000_0000);

  assert_full_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_field == 3'd0) |=> ctrl_word == ($past(wr_data) & 32'hF000_FFFF));

  assert_run_field_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_field == 3'd3) |=>
      (ctrl_word[7:4] == $past(wr_data[3:0])) &&
      ({ctrl_word[31:8], ctrl_word[3:0]} == $past({ctrl_word[31:8], ctrl_word[3:0]})));

  assert_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || wr_field > 3'd5) |=> $stable(ctrl_word));

  assert_run_pick_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[31:28] == 4'd2 && {1'b0, ctrl_word[7:4]} < N_LIM) |=>
      (src_valid && active_src == $past(ctrl_word[7:4])));

  assert_standby_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[31:28] == 4'd0) |=> !src_valid);

  assert_code_range_R6: assert property (@(posedge clk) disable iff (rst)
    src_valid |-> ({1'b0, active_src} < N_LIM));

  assert_one_gate_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate_en));

endmodule

bind cpu_clk_state_mux cksel_chk #(.N_SRC(N_SRC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_field   (wr_field),
  .wr_data    (wr_data),
  .ctrl_word  (ctrl_word),
  .active_src (active_src),
  .src_valid  (src_valid),
  .gate_en    (gate_en)
);

// File: tb/cpu_clk_state_mux_tb.sv
`timescale 1ns/1ps
module cpu_clk_state_mux_tb;

  localparam int  N         = 9;
  localparam real HALF_MIN  = 2.0;
  localparam real HALF_STEP = 0.35;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_field = 3'd0;
  logic [31:0] wr_data = 32'd0;
  wire  [N-1:0] src_clk;
  logic [31:0] ctrl_word;
  logic [3:0]  active_src;
  logic        src_valid;
  logic        clk_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] model = 32'h2000_0000;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic c = 1'b0;
    initial begin
      #(0.37 * g);
      forever #(HALF_MIN + HALF_STEP * g) c = ~c;
    end
    assign src_clk[g] = c;
  end

  cpu_clk_state_mux #(.N_SRC(N)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_field   (wr_field),
    .wr_data    (wr_data),
    .src_clk    (src_clk),
    .ctrl_word  (ctrl_word),
    .active_src (active_src),
    .src_valid  (src_valid),
    .clk_out    (clk_out)
  );

  // Edge counters and output pulse-width monitor
  int unsigned src_cnt [N];
  int unsigned out_cnt = 0;
  logic [N-1:0] src_prev = '0;
  bit  track = 1'b0;
  real last_edge = -1.0;
  real min_pulse = 1.0e9;

  always @(src_clk) begin
    for (int i = 0; i < N; i++)
      if (src_clk[i] && !src_prev[i]) src_cnt[i]++;
    src_prev = src_clk;
  end

  always @(clk_out) begin
    if (track) begin
      if (clk_out === 1'b1) out_cnt++;
      if (last_edge >= 0.0 && ($realtime - last_edge) < min_pulse)
        min_pulse = $realtime - last_edge;
      last_edge = $realtime;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Field value picked by the state, or -1 for standby / unused state codes.
  function automatic int exp_pick(input logic [31:0] w);
    case (w[31:28])
      4'd1: return int'(w[3:0]);
      4'd2: return int'(w[7:4]);
      4'd3: return int'(w[11:8]);
      4'd4: return int'(w[15:12]);
      default: return -1;
    endcase
  endfunction

  function automatic string sel_tag(input logic [31:0] w);
    int p;
    p = exp_pick(w);
    if (p < 0) return "R5";
    if (p >= N) return "R6";
    return "R4";
  endfunction

  task automatic check_sel();
    int p;
    p = exp_pick(model);
    chk(src_valid == (p >= 0 && p < N), sel_tag(model), "src_valid",
        longint'(src_valid), longint'(p >= 0 && p < N));
    chk(active_src == 4'((p < 0) ? 0 : p), sel_tag(model), "active_src",
        longint'(active_src), longint'((p < 0) ? 0 : p));
  endtask

  task automatic check_clock(input string req);
    int p;
    int unsigned s0;
    int unsigned o0;
    int unsigned ds;
    int unsigned dout;
    p = exp_pick(model);
    #120;
    o0 = out_cnt;
    s0 = (p >= 0 && p < N) ? src_cnt[p] : 0;
    #300;
    dout = out_cnt - o0;
    if (p >= 0 && p < N) begin
      ds = src_cnt[p] - s0;
      // R10: a second open gate would add extra edges here
      chk((dout + 1 >= ds) && (dout <= ds + 1), req, "output edges vs selected source (R8 R10)",
          longint'(dout), longint'(ds));
    end else begin
      chk(dout == 0 && clk_out == 1'b0, req, "output held low edges",
          longint'(dout), 0);
    end
  endtask

  task automatic do_write(input logic [2:0] f, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_field = f; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (f)
      3'd0: model = d & 32'hF000_FFFF;
      3'd1: model[31:28] = d[3:0];
      3'd2: model[3:0]   = d[3:0];
      3'd3: model[7:4]   = d[3:0];
      3'd4: model[11:8]  = d[3:0];
      3'd5: model[15:12] = d[3:0];
      default: ;
    endcase
    chk(ctrl_word == model, (f == 3'd0) ? "R2" : "R3", "ctrl_word",
        longint'(ctrl_word), longint'(model));
    @(negedge clk);
    check_sel();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected run end");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (12) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    track = 1'b1;

    // R1: reset contents and selection of input 0
    chk(ctrl_word == 32'h2000_0000, "R1", "reset ctrl_word", longint'(ctrl_word), 64'h2000_0000);
    @(negedge clk);
    chk(src_valid && active_src == 4'd0, "R1", "reset selection",
        longint'({src_valid, active_src}), 64'h10);
    check_clock("R1");

    // R2: whole-word write, upper reserved bits must not stick
    do_write(3'd0, 32'h1FFF_8713);
    check_clock("R4");

    // R7: state-only changes move the output
    do_write(3'd1, 32'd2);
    check_clock("R7");
    do_write(3'd1, 32'd3);
    check_clock("R7");
    do_write(3'd1, 32'd4);   // FIQ source 8, the highest implemented code
    check_clock("R7");

    // R6: out-of-range code on the active field
    do_write(3'd5, 32'd9);
    check_clock("R6");
    do_write(3'd5, 32'd15);
    check_clock("R6");

    // R5: standby and an unused state code
    do_write(3'd1, 32'd0);
    check_clock("R5");
    do_write(3'd1, 32'd6);
    check_clock("R5");

    // R3: ignored targets and single-field update
    do_write(3'd6, 32'hFFFF_FFFF);
    do_write(3'd7, 32'h0000_0005);
    do_write(3'd1, 32'd2);
    do_write(3'd3, 32'd5);
    check_clock("R3");

    // Random mix of writes landing at arbitrary phases
    for (int it = 0; it < 22; it++) begin
      logic [2:0]  f;
      logic [31:0] d;
      f = 3'($urandom % 8);
      d = $urandom;
      if (f == 3'd0) begin
        d[31:28] = 4'($urandom % 7);
        for (int k = 0; k < 4; k++)
          d[4*k +: 4] = ($urandom % 5 == 0) ? 4'($urandom % 16) : 4'($urandom % N);
      end else if (f == 3'd1) begin
        d[3:0] = 4'($urandom % 7);
      end else begin
        d[3:0] = ($urandom % 5 == 0) ? 4'($urandom % 16) : 4'($urandom % N);
      end
      do_write(f, d);
      check_clock(sel_tag(model));
    end

    // R9: narrowest output pulse over the whole run
    chk(min_pulse >= HALF_MIN - 0.01, "R9", "narrowest output pulse (ps)",
        longint'(min_pulse * 1000.0), longint'(HALF_MIN * 1000.0));

    finish_run();
  end

endmodule